// File: doc/BRIEF.md
# Port Data Clock Generator

This block derives the data clock of a parallel sample port from the system clock. A counter divides the system clock by a ratio supplied on an input. It produces a free-running internal copy of the port clock, a gated copy for the output pin, and a single-cycle capture strobe. The strobe fires in the same cycle as each active edge of the internal clock. With each strobe the block reports which edge fired and whether the word taken on that edge is an I word or a Q word.

Three port modes are supported. In quadrature mode, I and Q words alternate on the port. In interpolating mode, every word is a single real sample. In serial mode, the clock marks each bit of two serial streams. A half-rate option, which applies only to quadrature mode, slows the clock by two. It then takes I words on one edge and Q words on the other. New divide ratio, mode, polarity and rate settings are sampled only at the start of a clock period, so the output never shows a shortened pulse. The reset input is asynchronous and active low, and it is released to the logic through a two-flop synchronizer.

Top module: `port_clk_gen`

## Requirements
- R1: While reset is held, and after reset is released, `pclk_int_o`, `pclk_pin_o` and `cap_stb_o` are 0. In quadrature mode without half rate, the first capture after reset is an I word (`cap_is_q_o`=0).
- R2: Without half rate, `pclk_int_o` has a period of `div_ratio_i` system clocks. For an even ratio it is high for half of the period.
- R3: With `pclk_inv_i`=0 and no half rate, `cap_stb_o` pulses for one cycle in exactly the cycles where `pclk_int_o` has just become 1, with `cap_rise_o`=1. With `pclk_inv_i`=1, it pulses where `pclk_int_o` has just become 0, with `cap_rise_o`=0.
- R4: With `pclk_en_i`=0, `pclk_pin_o` is 0 and `pclk_int_o` keeps toggling. With `pclk_en_i`=1, `pclk_pin_o` equals `pclk_int_o`.
- R5: In quadrature mode (`port_mode_i`=2'b00) with `half_rate_i`=1 and `pclk_inv_i`=0, the period is twice `div_ratio_i`. The strobe fires on both edges: rising edges carry I words (`cap_is_q_o`=0) and falling edges carry Q words (`cap_is_q_o`=1).
- R6: In half-rate quadrature mode with `pclk_inv_i`=1, rising edges carry Q words and falling edges carry I words.
- R7: In quadrature mode without half rate, successive strobes alternate between I and Q.
- R8: In interpolating mode (2'b01, and 2'b11 acts the same) and serial mode (2'b10), `cap_is_q_o` stays 0 and `half_rate_i` has no effect on the period.
- R9: A change to the ratio, mode, polarity or rate takes effect only at the next falling edge of `pclk_int_o`, which is the counter wrap. The period in progress finishes with the old setting.
- R10: A `div_ratio_i` of 0 or 1 acts as a ratio of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pclk_en_i | input | 1 | Drive the port clock onto the pin |
| pclk_inv_i | input | 1 | Falling edge is the capture edge; swaps I/Q edges in half rate |
| half_rate_i | input | 1 | Half-rate, both-edge I/Q capture (quadrature mode only) |
| port_mode_i | input | 2 | 00 quadrature, 01 interpolating, 10 serial, 11 as interpolating |
| div_ratio_i | input | DIV_W | System clocks per port clock period |
| pclk_int_o | output | 1 | Internal port clock, always running |
| pclk_pin_o | output | 1 | Gated port clock for the pin |
| cap_stb_o | output | 1 | One-cycle strobe on each active edge |
| cap_rise_o | output | 1 | Strobe came from a rising edge |
| cap_is_q_o | output | 1 | Word at this strobe is a Q word |

## Verification
A counter that does not wrap at the right point shows up as a wrong distance between two rising edges of `pclk_int_o`, so it is visible within one period. A config register loaded in the middle of a period shows up as a shortened high or low phase on the very next edge. A wrong pair bit or polarity bit shows up at the next strobe, in `cap_is_q_o` or `cap_rise_o`. A gating error on the pin shows up one cycle after the enable changes.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  typedef enum logic [1:0] {
    MODE_QUAD   = 2'b00,
    MODE_INTERP = 2'b01,
    MODE_SERIAL = 2'b10,
    MODE_RSVD   = 2'b11
  } port_mode_e;

  typedef struct packed {
    logic       inv;
    logic       half;
    port_mode_e mode;
  } pclk_flags_t;
endpackage

// File: rtl/pclk_cfg_hold.sv
module pclk_cfg_hold
  import pclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             at_start_i,
  input  logic [DIV_W-1:0] div_i,
  input  pclk_flags_t      flags_i,
  output logic [DIV_W-1:0] div_o,
  output pclk_flags_t      flags_o
);
  localparam logic [DIV_W-1:0] MinDiv = DIV_W'(2);

  logic [DIV_W-1:0] held_div;
  pclk_flags_t      held_flags;
  logic [DIV_W-1:0] live_div;
  pclk_flags_t      live_flags;

  always_comb begin
    live_div        = (div_i < MinDiv) ? MinDiv : div_i;
    live_flags      = flags_i;
    live_flags.half = flags_i.half & (flags_i.mode == MODE_QUAD);
    div_o           = at_start_i ? live_div   : held_div;
    flags_o         = at_start_i ? live_flags : held_flags;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      held_div   <= MinDiv;
      held_flags <= '0;
    end else begin
      held_div   <= div_o;
      held_flags <= flags_o;
    end
  end

  // R9: the settings in use move only at the start of a period
  p_cfg_wrap_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (!$stable(div_o) || !$stable(flags_o)) |-> at_start_i);
endmodule

// File: rtl/pclk_counter.sv
module pclk_counter #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             half_i,
  output logic             at_start_o,
  output logic             lvl_o,
  output logic             lvl_nxt_o
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_nxt, period, mid;

  always_comb begin
    period     = half_i ? {div_i, 1'b0} : {1'b0, div_i};
    mid        = period >> 1;
    cnt_nxt    = (cnt_q >= period - 1'b1) ? '0 : cnt_q + 1'b1;
    lvl_nxt_o  = (cnt_nxt >= mid);
    at_start_o = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_o <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      lvl_o <= lvl_nxt_o;
    end
  end

  // R2: the count stays inside the period in use
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q < period);
  // R9: the clock falls only when the count wraps
  p_fall_at_wrap_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(lvl_o) |-> at_start_o);
endmodule

// File: rtl/pclk_strobe.sv
module pclk_strobe
  import pclk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_ni,
  input  logic        lvl_i,
  input  logic        lvl_nxt_i,
  input  logic        en_i,
  input  pclk_flags_t flags_i,
  output logic        pin_o,
  output logic        stb_o,
  output logic        rise_o,
  output logic        is_q_o
);
  logic pair_q, pair_nxt;
  logic rise_ev, fall_ev, act, quad_norm;
  logic pin_nxt, stb_nxt, rise_nxt, q_nxt;

  always_comb begin
    rise_ev   = lvl_nxt_i & ~lvl_i;
    fall_ev   = ~lvl_nxt_i & lvl_i;
    quad_norm = (flags_i.mode == MODE_QUAD) & ~flags_i.half;
    if (flags_i.half) act = rise_ev | fall_ev;
    else              act = flags_i.inv ? fall_ev : rise_ev;
    pin_nxt  = lvl_nxt_i & en_i;
    stb_nxt  = act;
    rise_nxt = act & rise_ev;
    q_nxt    = 1'b0;
    pair_nxt = pair_q;
    if (!quad_norm) pair_nxt = 1'b0;
    else if (act)   pair_nxt = ~pair_q;
    if (act) begin
      if (flags_i.half)   q_nxt = rise_ev ? flags_i.inv : ~flags_i.inv;
      else if (quad_norm) q_nxt = pair_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pair_q <= 1'b0;
      pin_o  <= 1'b0;
      stb_o  <= 1'b0;
      rise_o <= 1'b0;
      is_q_o <= 1'b0;
    end else begin
      pair_q <= pair_nxt;
      pin_o  <= pin_nxt;
      stb_o  <= stb_nxt;
      rise_o <= rise_nxt;
      is_q_o <= q_nxt;
    end
  end

  // R4: pin forced low one cycle after enable drops
  p_pin_gate_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    !en_i |=> !pin_o);
  // R4: pin high only while the internal clock is high
  p_pin_follow_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    pin_o |-> lvl_i);
  // R3: a strobe only ever marks a level change of the internal clock
  p_stb_edge_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    stb_o |-> (lvl_i != $past(lvl_i)));
  // R3: single-edge capture uses the edge picked by the polarity bit
  p_one_edge_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (stb_o && !$past(flags_i.half)) |-> (rise_o != $past(flags_i.inv)));
endmodule

// File: rtl/port_clk_gen.sv
module port_clk_gen
  import pclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pclk_en_i,
  input  logic             pclk_inv_i,
  input  logic             half_rate_i,
  input  logic [1:0]       port_mode_i,
  input  logic [DIV_W-1:0] div_ratio_i,
  output logic             pclk_int_o,
  output logic             pclk_pin_o,
  output logic             cap_stb_o,
  output logic             cap_rise_o,
  output logic             cap_is_q_o
);
  logic             rst_meta, rst_sync;
  logic             at_start, lvl_nxt;
  logic [DIV_W-1:0] cur_div;
  pclk_flags_t      live_flags, cur_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  always_comb begin
    live_flags.inv  = pclk_inv_i;
    live_flags.half = half_rate_i;
    live_flags.mode = port_mode_e'(port_mode_i);
  end

  pclk_cfg_hold #(.DIV_W(DIV_W)) u_cfg (
    .clk       (clk),
    .rst_ni    (rst_sync),
    .at_start_i(at_start),
    .div_i     (div_ratio_i),
    .flags_i   (live_flags),
    .div_o     (cur_div),
    .flags_o   (cur_flags)
  );

  pclk_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk       (clk),
    .rst_ni    (rst_sync),
    .div_i     (cur_div),
    .half_i    (cur_flags.half),
    .at_start_o(at_start),
    .lvl_o     (pclk_int_o),
    .lvl_nxt_o (lvl_nxt)
  );

  pclk_strobe u_stb (
    .clk      (clk),
    .rst_ni   (rst_sync),
    .lvl_i    (pclk_int_o),
    .lvl_nxt_i(lvl_nxt),
    .en_i     (pclk_en_i),
    .flags_i  (cur_flags),
    .pin_o    (pclk_pin_o),
    .stb_o    (cap_stb_o),
    .rise_o   (cap_rise_o),
    .is_q_o   (cap_is_q_o)
  );

  // R1: outputs quiet while the synchronized reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_sync |=> (!cap_stb_o && !pclk_pin_o));
endmodule

// File: tb/port_clk_gen_bench.sv
module port_clk_gen_bench;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic en, inv, half;
  logic [1:0] mode;
  logic [DIV_W-1:0] div;
  logic pint, pin, stb, rise, isq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  port_clk_gen #(.DIV_W(DIV_W)) u_port_clk_gen (
    .clk(clk), .rst_n(rst_n), .pclk_en_i(en), .pclk_inv_i(inv),
    .half_rate_i(half), .port_mode_i(mode), .div_ratio_i(div),
    .pclk_int_o(pint), .pclk_pin_o(pin), .cap_stb_o(stb),
    .cap_rise_o(rise), .cap_is_q_o(isq)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_period();
    int d = (div < 2) ? 2 : int'(div);
    return (half && mode == 2'b00) ? 2 * d : d;
  endfunction

  task automatic setcfg(bit e, bit i, bit h, logic [1:0] m, int d);
    @(negedge clk);
    en = e; inv = i; half = h; mode = m; div = DIV_W'(d);
    repeat (40) @(negedge clk);
  endtask

  // Watch n cycles and compare every port with the rules for the current settings
  task automatic observe(int n, string tag);
    bit   prev = pint;
    int   last_rise = -1;
    int   last_q = -1;
    int   per = exp_period();
    bit   hr = half && mode == 2'b00;
    bit   qn = (mode == 2'b00) && !hr;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      begin
        bit r = pint & ~prev;
        bit f = ~pint & prev;
        bit es = hr ? (r | f) : (inv ? f : r);
        chk(stb == es, {tag, " strobe"}, stb, es);
        chk(pin == (en & pint), {tag, " pin"}, pin, en & pint);
        if (stb) begin
          chk(rise == r, {tag, " edge"}, rise, r);
          if (hr) chk(isq == (r ? inv : !inv), {tag, " iq"}, isq, r ? inv : !inv);
          else if (qn) begin
            if (last_q >= 0) chk(int'(isq) != last_q, {tag, " R7 alternate"}, isq, !last_q);
            last_q = isq;
          end else chk(isq == 1'b0, {tag, " R8 no-Q"}, isq, 0);
        end
        if (r) begin
          if (last_rise >= 0) chk(t - last_rise == per, {tag, " period"}, t - last_rise, per);
          last_rise = t;
        end
        prev = pint;
      end
    end
  endtask

  task automatic t_reset();
    int seen = 0;
    rst_n = 1'b0; en = 1; inv = 0; half = 0; mode = 2'b00; div = 8'd4;
    repeat (3) @(negedge clk);
    chk({pint, pin, stb} == 3'b000, "R1 during reset", {pint, pin, stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({pint, pin, stb} == 3'b000, "R1 after release", {pint, pin, stb}, 0);
    for (int t = 0; t < 30 && !seen; t++) begin
      @(negedge clk);
      if (stb) begin
        seen = 1;
        chk(isq == 1'b0, "R1 first word is I", isq, 0);
      end
    end
    chk(seen == 1, "R1 strobe appears", seen, 1);
  endtask

  task automatic t_normal();
    setcfg(1, 0, 0, 2'b01, 4);  observe(40, "R2 R3 div4 rising");
    setcfg(1, 0, 0, 2'b01, 10); observe(60, "R2 div10");
  endtask

  task automatic t_invert();
    setcfg(1, 1, 0, 2'b01, 6); observe(50, "R3 falling");
  endtask

  task automatic t_enable();
    int toggles = 0;
    bit p;
    setcfg(0, 0, 0, 2'b01, 4);
    observe(40, "R4 disabled");
    p = pint;
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      if (pint != p) toggles++;
      p = pint;
      chk(pin == 1'b0, "R4 pin low", pin, 0);
    end
    chk(toggles >= 8, "R4 internal runs", toggles, 10);
    setcfg(1, 0, 0, 2'b01, 4); observe(20, "R4 enabled");
  endtask

  task automatic t_half();
    setcfg(1, 0, 1, 2'b00, 4); observe(60, "R5 half rate");
  endtask

  task automatic t_half_inv();
    setcfg(1, 1, 1, 2'b00, 6); observe(60, "R6 half rate inverted");
  endtask

  task automatic t_quad();
    setcfg(1, 0, 0, 2'b00, 6); observe(60, "R7 quad");
    setcfg(1, 1, 0, 2'b00, 4); observe(40, "R7 quad inverted");
  endtask

  task automatic t_other_modes();
    setcfg(1, 0, 1, 2'b01, 4); observe(40, "R8 interp half ignored");
    setcfg(1, 0, 1, 2'b10, 6); observe(40, "R8 serial half ignored");
    setcfg(1, 0, 0, 2'b11, 4); observe(40, "R8 mode 11");
  endtask

  task automatic t_wrap();
    bit prev;
    int n = 0;
    bit hit = 0;
    setcfg(1, 0, 0, 2'b01, 4);
    prev = pint;
    for (int t = 0; t < 20 && !hit; t++) begin
      @(negedge clk);
      if (pint && !prev) hit = 1;
      prev = pint;
    end
    div = 8'd8;  // change right after a rising edge
    while (pint && n < 40) begin @(negedge clk); n++; end
    chk(n == 2, "R9 old high phase kept", n, 2);
    n = 0;
    while (!pint && n < 40) begin @(negedge clk); n++; end
    chk(n == 4, "R9 new low phase", n, 4);
  endtask

  task automatic t_min_div();
    setcfg(1, 0, 0, 2'b01, 0); observe(20, "R10 div0");
    setcfg(1, 0, 0, 2'b01, 1); observe(20, "R10 div1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_normal();
    t_invert();
    t_enable();
    t_half();
    t_half_inv();
    t_quad();
    t_other_modes();
    t_wrap();
    t_min_div();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule